// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block holds a file of 256 byte-wide configuration registers and exposes them through a window of only two byte locations. Software first writes a register number to the index location, then reads or writes the data location to reach the selected register. Each write to the data location passes through a fixed filter that depends on the index. Many indices are read-only. Two indices accept exactly one permitted byte value each. All remaining indices take any byte.

A single enable input, normally wired to bit 1 of a configuration byte held elsewhere, gates the whole window. While it is low, writes change nothing and reads return all ones. On reset, the index points at register 0x00 and six registers load non-zero defaults. The host side is a plain strobe bus. `portSel` picks the location, `wrStb` and `rdStb` are single-cycle strobes, and read data is registered.

Top module: `cfgwin_port`

## Requirements
- R1: After reset the index is 0x00, registers 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 hold 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE, every other register holds 0x00, and `rdData` is 0x00.
- R2: While `winEnable` is low, a write at either location changes neither the index nor any register.
- R3: A read strobe while `winEnable` is low makes `rdData` 0xFF on the next cycle.
- R4: With `winEnable` high, a write with `portSel`=0 loads `wrData` into the index.
- R5: With `winEnable` high, a read strobe at either `portSel` value makes `rdData` equal to the register selected by the index on the next cycle, and `rdData` holds when no read strobe is given.
- R6: A data write (`portSel`=1) is ignored when the index is in 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R7: A data write to index 0xE7 is stored only when the byte is 0xFE. Any other byte leaves the register unchanged.
- R8: A data write to index 0xE8 is stored only when the byte is 0xBE. Any other byte leaves the register unchanged.
- R9: A data write to any index not named in R6–R8 (such as 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8, 0xFC) stores the full byte.
- R10: When a read strobe and a data write to the same register arrive in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| winEnable | input | 1 | Window decode enable (bit 1 of an external config byte) |
| wrStb | input | 1 | Write strobe, one cycle |
| rdStb | input | 1 | Read strobe, one cycle |
| portSel | input | 1 | 0 selects the index location, 1 selects the data location |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Registered read byte |

## Verification
The hardest case to reach is a filtered write that must leave no trace. A rejected byte at 0xE7 or 0xE8 is only visible as a register that kept its default. For that reason, the bench follows every such write with a read through the same index and compares against the default it computes itself. The write that lands in the same cycle as a read is driven with both strobes raised together. That is the only way to show that the registered read takes the old value. Disabled-window writes are checked by enabling the window again and reading back the register the index still points at.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 8;
  localparam int NUM_REGS = 1 << IDX_W;

  typedef struct packed {
    logic idxLoad;
    logic dataWr;
    logic rdLoad;
    logic rdBlank;
  } winStrobes_t;

  // Index-dependent write filter; the index map is fixed behaviour.
  function automatic logic wrPermitted(input logic [7:0] idx, input logic [7:0] val);
    case (idx) inside
      [8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3, 8'hF5, 8'hF7,
      [8'hF9:8'hFB], [8'hFD:8'hFF]: return 1'b0;
      8'hE7:   return val == 8'hFE;
      8'hE8:   return val == 8'hBE;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] resetValue(input logic [7:0] idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
(
  input  logic        winEnable,
  input  logic        wrStb,
  input  logic        rdStb,
  input  logic        portSel,
  output winStrobes_t stb
);
  always_comb begin
    stb.idxLoad = winEnable && wrStb && !portSel;
    stb.dataWr  = winEnable && wrStb && portSel;
    stb.rdLoad  = rdStb;
    stb.rdBlank = !winEnable;
  end
endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W,
  localparam int NR = 1 << IW
) (
  input  logic          clk,
  input  logic          rstN,
  input  winStrobes_t   stb,
  input  logic [DW-1:0] wrData,
  output logic [IW-1:0] curIdx,
  output logic [DW-1:0] selData,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] regFile [NR];
  logic          wrOk;

  assign wrOk    = stb.dataWr && wrPermitted(8'(curIdx), 8'(wrData));
  assign selData = regFile[curIdx];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    localparam logic [DW-1:0] RST_VAL = DW'(resetValue(8'(g)));
    always_ff @(posedge clk) begin
      if (!rstN)                          regFile[g] <= RST_VAL;
      else if (wrOk && curIdx == IW'(g))  regFile[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx <= '0;
      rdData <= '0;
    end else begin
      if (stb.idxLoad) curIdx <= IW'(wrData);
      if (stb.rdLoad)  rdData <= stb.rdBlank ? '1 : selData;
    end
  end
endmodule

// File: rtl/cfgwin_port.sv
module cfgwin_port
  import cfgwin_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             winEnable,
  input  logic             wrStb,
  input  logic             rdStb,
  input  logic             portSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  winStrobes_t             stb;
  logic [IDX_W-1:0]        curIdx;
  logic [DATA_W-1:0]       selData;

  cfgwin_ctrl u_ctrl (
    .winEnable(winEnable), .wrStb(wrStb), .rdStb(rdStb),
    .portSel(portSel), .stb(stb)
  );

  cfgwin_regs #(.DW(DATA_W), .IW(IDX_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .curIdx(curIdx), .selData(selData), .rdData(rdData)
  );
endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk (
  input logic       clk,
  input logic       rstN,
  input logic       winEnable,
  input logic       wrStb,
  input logic       rdStb,
  input logic       portSel,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [7:0] curIdx,
  input logic [7:0] selData
);
  // R2
  dis_idx_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!winEnable && wrStb) |=> $stable(curIdx));
  // R2
  dis_reg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!winEnable && wrStb && portSel) |=> $stable(selData));
  // R3
  dis_read_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!winEnable && rdStb) |=> rdData == 8'hFF);
  // R4
  idx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winEnable && wrStb && !portSel) |=> curIdx == $past(wrData));
  // R5
  read_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winEnable && rdStb) |=> rdData == $past(selData));
  // R5
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(rdData));
  // R6
  ro_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winEnable && wrStb && portSel && curIdx <= 8'hDF) |=> $stable(selData));
  // R7
  magic_e7_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winEnable && wrStb && portSel && curIdx == 8'hE7 && wrData != 8'hFE) |=> $stable(selData));
  // R8
  magic_e8_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winEnable && wrStb && portSel && curIdx == 8'hE8 && wrData != 8'hBE) |=> $stable(selData));
  // R9
  free_e1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winEnable && wrStb && portSel && curIdx == 8'hE1) |=> selData == $past(wrData));
endmodule

bind cfgwin_port cfgwin_chk u_chk (
  .clk(clk), .rstN(rstN), .winEnable(winEnable), .wrStb(wrStb),
  .rdStb(rdStb), .portSel(portSel), .wrData(wrData), .rdData(rdData),
  .curIdx(curIdx), .selData(selData)
);

// File: tb/tb_cfgwin_port.sv
module tb_cfgwin_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic winEnable = 1'b0;
  logic wrStb = 1'b0;
  logic rdStb = 1'b0;
  logic portSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cfgwin_port dut (
    .clk(clk), .rstN(rstN), .winEnable(winEnable), .wrStb(wrStb),
    .rdStb(rdStb), .portSel(portSel), .wrData(wrData), .rdData(rdData)
  );

  // op: 0 = write index, 1 = write data, 2 = read data and compare
  localparam int NV = 30;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'hE1, 8'h00}, {2'd1, 8'h5A, 8'h00}, {2'd2, 8'h00, 8'h5A},
    {2'd0, 8'h10, 8'h00}, {2'd1, 8'h77, 8'h00}, {2'd2, 8'h00, 8'h00},
    {2'd0, 8'hE7, 8'h00}, {2'd1, 8'h12, 8'h00}, {2'd2, 8'h00, 8'hFE},
    {2'd1, 8'hFE, 8'h00}, {2'd2, 8'h00, 8'hFE},
    {2'd0, 8'hE8, 8'h00}, {2'd1, 8'h00, 8'h00}, {2'd2, 8'h00, 8'hBE},
    {2'd1, 8'hBE, 8'h00}, {2'd2, 8'h00, 8'hBE},
    {2'd0, 8'hF3, 8'h00}, {2'd1, 8'h11, 8'h00}, {2'd2, 8'h00, 8'h00},
    {2'd0, 8'hFC, 8'h00}, {2'd1, 8'hC3, 8'h00}, {2'd2, 8'h00, 8'hC3},
    {2'd0, 8'hE4, 8'h00}, {2'd1, 8'h99, 8'h00}, {2'd2, 8'h00, 8'h00},
    {2'd0, 8'hEE, 8'h00}, {2'd1, 8'h01, 8'h00}, {2'd2, 8'h00, 8'h01},
    {2'd0, 8'hE0, 8'h00}, {2'd1, 8'hA5, 8'h00}
  };
  localparam logic [3:0] VREQ [NV] = '{
    9,9,9, 6,6,6, 7,7,7, 7,7, 8,8,8, 8,8, 6,6,6, 9,9,9, 6,6,6, 9,9,9, 9,9};

  function automatic logic [7:0] expDefault(input int i);
    case (i)
      'hE0: return 8'h3C; 'hE2: return 8'h03; 'hE3: return 8'hFC;
      'hE6: return 8'hDE; 'hE7: return 8'hFE; 'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic sel, input logic [7:0] d);
    @(negedge clk); wrStb = 1'b1; portSel = sel; wrData = d;
    @(negedge clk); wrStb = 1'b0;
  endtask

  task automatic busRd(input logic sel, output logic [7:0] d);
    @(negedge clk); rdStb = 1'b1; portSel = sel;
    @(negedge clk); rdStb = 1'b0; d = rdData;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData after reset", rdData, 8'h00);
    winEnable = 1'b1;
    busRd(1'b1, got);
    check("R1 index zero after reset", got, 8'h00);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][17:16])
        2'd0: busWr(1'b0, VEC[v][15:8]);
        2'd1: busWr(1'b1, VEC[v][15:8]);
        default: begin
          busRd(1'b1, got);
          check($sformatf("R%0d vector %0d", VREQ[v], v), got, VEC[v][7:0]);
        end
      endcase
    end
    // read at index location returns selected register (E0 = A5)
    busRd(1'b0, got);
    check("R5 read at index location", got, 8'hA5);
    @(negedge clk);
    check("R5 rdData holds without strobe", rdData, 8'hA5);

    // R10: same-cycle read and write at index E1 (holds 5A)
    busWr(1'b0, 8'hE1);
    @(negedge clk); wrStb = 1'b1; rdStb = 1'b1; portSel = 1'b1; wrData = 8'h3C;
    @(negedge clk); wrStb = 1'b0; rdStb = 1'b0;
    check("R10 read returns old value", rdData, 8'h5A);
    busRd(1'b1, got);
    check("R10 write landed", got, 8'h3C);

    // R2/R3: disabled window
    winEnable = 1'b0;
    busRd(1'b1, got);
    check("R3 disabled read", got, 8'hFF);
    busWr(1'b1, 8'h99);
    busWr(1'b0, 8'hE2);
    winEnable = 1'b1;
    busRd(1'b1, got);
    check("R2 disabled writes ignored", got, 8'h3C);

    // R1: reset after dirtying, check every register default
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 256; i++) begin
      busWr(1'b0, 8'(i));
      busRd(1'b1, got);
      check($sformatf("R1 default of %02h", i), got, expDefault(i));
    end
    finishRun();
  end
endmodule